// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block keeps the 16-bit processor status word of a small CPU core. It takes decoded instruction events as strobes and updates single fields of the word from them. The events are accumulator loads that fix the operand width, dedicated data-width set and clear, user-flag set and clear, ALU results, full word writes, interrupt entry and interrupt return. The instruction decoder, the ALU and the stack all sit outside. The block only holds the word and applies the ordering rules between these events.

Two fields need special timing. The data-width bit (bit 12, 1 = word operations) can change in two ways. A change from an accumulator load or a dedicated set/clear is seen by the following instruction. A change from any other write reaches the following instruction one slot late. The master interrupt enable (bit 8) is handled by a small sequencer with three states. `ST_RUN` is normal execution. `ST_SAVE` is the slot after an accepted interrupt entry, when the stacked image has been captured but the enable bit is still set. `ST_ISR` is the service routine. Its transitions are named *enter* (`ST_RUN`→`ST_SAVE` on `irq_entry`), *mask* (`ST_SAVE`→`ST_ISR`, unconditional) and *return* (`ST_ISR`→`ST_RUN` on `rti`). Every clock cycle is one instruction slot. The three-bit pointer-register set select in bits 2:0 is stored and output only.

Top module: `psw_unit`

## Requirements
- R1: A synchronous active-high reset sets the status word, the stacked image and the data-width view to zero, so interrupts are disabled and byte width is selected.
- R2: Bits 15:13 of the status word always read zero, whatever value a write or a return supplies.
- R3: A word-size accumulator load or dedicated set makes bit 12 equal to 1. A byte-size load or dedicated clear makes it 0. The set sources win when both kinds are strobed together. `dd_seen` shows the new value in the very next cycle.
- R4: When bit 12 changes through a full write or a return, `psw[12]` takes the new value after the edge. `dd_seen` shows the previous bit 12 for that one cycle and follows in the cycle after.
- R5: On `alu_valid`, sign bit 11 takes result bit 7 for a byte operation (`alu_word`=0) or bit 15 for a word operation (`alu_word`=1).
- R6: On `alu_valid` with `alu_arith`=1, overflow bit 9 is set when the 17-bit signed `alu_result` lies outside -128..127 (byte) or -32768..32767 (word), and is cleared otherwise. A logic operation (`alu_arith`=0) leaves bit 9 unchanged.
- R7: User-flag index 0..5 maps to bits 3, 6, 10, 7, 4, 5. `uf_set[i]` makes that bit 1 and `uf_clr[i]` makes it 0, and set wins over clear.
- R8: A full write loads the whole word. A return accepted in `ST_ISR` loads `rti_psw` instead and wins over a write. Any flag event in the same cycle overrides the loaded value for the bits it touches, and untouched bits take the loaded value.
- R9: `irq_entry` in `ST_RUN` captures the status word as it stood before that edge into `push_img` and moves to `ST_SAVE`. At the next edge bit 8 is forced to 0 and the state moves to `ST_ISR`. Entry in any other state is ignored.
- R10: `rti` in `ST_ISR` reloads the word from `rti_psw`, which restores the enable bit, and returns to `ST_RUN`. `rti` in any other state has no effect. `mie` equals bit 8.
- R11: `irq_take` is `irq_pend` AND the current bit 8, and it is held low during `ST_SAVE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_ld_word | input | 1 | Word-size accumulator load |
| acc_ld_byte | input | 1 | Byte-size accumulator load |
| dd_set | input | 1 | Dedicated set of data-width bit |
| dd_clr | input | 1 | Dedicated clear of data-width bit |
| uf_set | input | 6 | User-flag set strobes |
| uf_clr | input | 6 | User-flag clear strobes |
| alu_valid | input | 1 | ALU result present |
| alu_word | input | 1 | ALU operation size, 1 = word |
| alu_arith | input | 1 | 1 = arithmetic, 0 = logic |
| alu_result | input | ALU_W+1 | Sign-extended exact ALU result |
| psw_wr_en | input | 1 | Full status word write |
| psw_wr_data | input | 16 | Write data |
| irq_entry | input | 1 | Maskable interrupt entry |
| rti | input | 1 | Return from interrupt |
| rti_psw | input | 16 | Status word popped on return |
| irq_pend | input | 1 | Pending maskable request |
| psw | output | 16 | Architectural status word |
| dd_seen | output | 1 | Data-width bit seen by the current instruction |
| push_img | output | 16 | Image captured at interrupt entry |
| mie | output | 1 | Master interrupt enable |
| irq_take | output | 1 | Effective interrupt request |

## Verification
The bench builds the block with the default `ALU_W` of 16, so a 17-bit result covers both the byte and the word overflow boundaries. Random values land on either side of -128/127 and -32768/32767 often, and directed values sit exactly on them. With this width the full user-flag mapping, the write/flag collisions and every sequencer path, including ignored entries and returns, are reached in a few thousand cycles.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int PSW_W   = 16;
    localparam int DD_BIT  = 12;
    localparam int SGN_BIT = 11;
    localparam int OV_BIT  = 9;
    localparam int MIE_BIT = 8;
    localparam int UF_N    = 6;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SAVE = 2'd1,
        ST_ISR  = 2'd2
    } irq_st_e;

    function automatic int uf_pos(input int idx);
        case (idx)
            0:       uf_pos = 3;
            1:       uf_pos = 6;
            2:       uf_pos = 10;
            3:       uf_pos = 7;
            4:       uf_pos = 4;
            default: uf_pos = 5;
        endcase
    endfunction
endpackage

// File: rtl/psw_alu_flags.sv
module psw_alu_flags #(
    parameter int ALU_W = 16
) (
    input  logic [ALU_W:0] result,
    input  logic           word,
    output logic           sign,
    output logic           ovf
);
    localparam int BYTE_W = ALU_W / 2;

    logic [ALU_W-BYTE_W+1:0] byte_hi;
    logic                    ovf_b;
    logic                    ovf_w;

    assign byte_hi = result[ALU_W:BYTE_W-1];
    assign ovf_b   = !((&byte_hi) || !(|byte_hi));
    assign ovf_w   = result[ALU_W] ^ result[ALU_W-1];

    assign sign = word ? result[ALU_W-1] : result[BYTE_W-1];
    assign ovf  = word ? ovf_w : ovf_b;
endmodule

// File: rtl/psw_irq_seq.sv
module psw_irq_seq
    import psw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    irq_entry,
    input  logic    rti,
    output irq_st_e state,
    output logic    entry_acc,
    output logic    rti_acc,
    output logic    mie_clr,
    output logic    take_gate
);
    irq_st_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (irq_entry) nxt = ST_SAVE;
            ST_SAVE: nxt = ST_ISR;
            ST_ISR:  if (rti) nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        entry_acc = 1'b0;
        rti_acc   = 1'b0;
        mie_clr   = 1'b0;
        take_gate = 1'b1;
        unique case (state)
            ST_RUN:  entry_acc = irq_entry;
            ST_SAVE: begin
                mie_clr   = 1'b1;
                take_gate = 1'b0;
            end
            ST_ISR:  rti_acc = rti;
            default: take_gate = 1'b0;
        endcase
    end
endmodule

// File: rtl/psw_dd_view.sv
module psw_dd_view (
    input  logic clk,
    input  logic rst,
    input  logic dd_hi,
    input  logic dd_lo,
    input  logic dd_arch,
    output logic dd_seen
);
    always_ff @(posedge clk) begin
        if (rst)        dd_seen <= 1'b0;
        else if (dd_hi) dd_seen <= 1'b1;
        else if (dd_lo) dd_seen <= 1'b0;
        else            dd_seen <= dd_arch;
    end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
#(
    parameter int ALU_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_ld_word,
    input  logic               acc_ld_byte,
    input  logic               dd_set,
    input  logic               dd_clr,
    input  logic [UF_N-1:0]    uf_set,
    input  logic [UF_N-1:0]    uf_clr,
    input  logic               alu_valid,
    input  logic               alu_word,
    input  logic               alu_arith,
    input  logic [ALU_W:0]     alu_result,
    input  logic               psw_wr_en,
    input  logic [PSW_W-1:0]   psw_wr_data,
    input  logic               irq_entry,
    input  logic               rti,
    input  logic [PSW_W-1:0]   rti_psw,
    input  logic               irq_pend,
    output logic [PSW_W-1:0]   psw,
    output logic               dd_seen,
    output logic [PSW_W-1:0]   push_img,
    output logic               mie,
    output logic               irq_take
);
    logic [PSW_W-1:0] psw_q;
    logic [PSW_W-1:0] psw_nxt;
    logic             dd_hi;
    logic             dd_lo;
    logic             alu_sign;
    logic             alu_ovf;
    irq_st_e          irq_state;
    logic             entry_acc;
    logic             rti_acc;
    logic             mie_clr;
    logic             take_gate;

    assign dd_hi = acc_ld_word | dd_set;
    assign dd_lo = acc_ld_byte | dd_clr;

    psw_alu_flags #(.ALU_W(ALU_W)) u_alu (
        .result (alu_result),
        .word   (alu_word),
        .sign   (alu_sign),
        .ovf    (alu_ovf)
    );

    psw_irq_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .irq_entry (irq_entry),
        .rti       (rti),
        .state     (irq_state),
        .entry_acc (entry_acc),
        .rti_acc   (rti_acc),
        .mie_clr   (mie_clr),
        .take_gate (take_gate)
    );

    psw_dd_view u_dd (
        .clk     (clk),
        .rst     (rst),
        .dd_hi   (dd_hi),
        .dd_lo   (dd_lo),
        .dd_arch (psw_q[DD_BIT]),
        .dd_seen (dd_seen)
    );

    always_comb begin
        psw_nxt = psw_q;
        if (rti_acc)        psw_nxt = rti_psw;
        else if (psw_wr_en) psw_nxt = psw_wr_data;
        psw_nxt[PSW_W-1:DD_BIT+1] = '0;

        if (dd_hi)      psw_nxt[DD_BIT] = 1'b1;
        else if (dd_lo) psw_nxt[DD_BIT] = 1'b0;

        for (int i = 0; i < UF_N; i++) begin
            if (uf_set[i])      psw_nxt[uf_pos(i)] = 1'b1;
            else if (uf_clr[i]) psw_nxt[uf_pos(i)] = 1'b0;
        end

        if (alu_valid) begin
            psw_nxt[SGN_BIT] = alu_sign;
            if (alu_arith) psw_nxt[OV_BIT] = alu_ovf;
        end

        if (mie_clr) psw_nxt[MIE_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q    <= '0;
            push_img <= '0;
        end else begin
            psw_q <= psw_nxt;
            if (entry_acc) push_img <= psw_q;
        end
    end

    assign psw      = psw_q;
    assign mie      = psw_q[MIE_BIT];
    assign irq_take = irq_pend & psw_q[MIE_BIT] & take_gate;
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk
    import psw_pkg::*;
#(
    parameter int ALU_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_ld_word,
    input logic             acc_ld_byte,
    input logic             dd_set,
    input logic             dd_clr,
    input logic             alu_valid,
    input logic             alu_word,
    input logic [ALU_W:0]   alu_result,
    input logic             irq_entry,
    input logic             irq_pend,
    input irq_st_e          st,
    input logic [PSW_W-1:0] psw,
    input logic             dd_seen,
    input logic [PSW_W-1:0] push_img,
    input logic             mie,
    input logic             irq_take
);
    localparam int BYTE_W = ALU_W / 2;

    p_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
        psw[PSW_W-1:DD_BIT+1] == '0);

    p_dd_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_ld_word | dd_set) |=> (dd_seen && psw[DD_BIT]));

    p_dd_lag_r4: assert property (@(posedge clk) disable iff (rst)
        !(acc_ld_word | dd_set | acc_ld_byte | dd_clr) |=> dd_seen == $past(psw[DD_BIT]));

    p_sign_byte_r5: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && !alu_word) |=> psw[SGN_BIT] == $past(alu_result[BYTE_W-1]));

    p_push_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && irq_entry) |=> push_img == $past(psw));

    p_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SAVE) |=> !psw[MIE_BIT]);

    p_take_r11: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (mie && irq_pend && st != ST_SAVE));
endmodule

bind psw_unit psw_unit_chk #(.ALU_W(ALU_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_ld_word (acc_ld_word),
    .acc_ld_byte (acc_ld_byte),
    .dd_set      (dd_set),
    .dd_clr      (dd_clr),
    .alu_valid   (alu_valid),
    .alu_word    (alu_word),
    .alu_result  (alu_result),
    .irq_entry   (irq_entry),
    .irq_pend    (irq_pend),
    .st          (irq_state),
    .psw         (psw),
    .dd_seen     (dd_seen),
    .push_img    (push_img),
    .mie         (mie),
    .irq_take    (irq_take)
);

// File: tb/tb_psw_unit.sv
module tb_psw_unit;
    localparam int ALU_W = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, acc_ld_word, acc_ld_byte, dd_set, dd_clr;
    logic [5:0] uf_set, uf_clr;
    logic alu_valid, alu_word, alu_arith;
    logic [ALU_W:0] alu_result;
    logic psw_wr_en, irq_entry, rti, irq_pend;
    logic [15:0] psw_wr_data, rti_psw, psw, push_img;
    logic dd_seen, mie, irq_take;

    psw_unit #(.ALU_W(ALU_W)) dut (
        .clk(clk), .rst(rst), .acc_ld_word(acc_ld_word), .acc_ld_byte(acc_ld_byte),
        .dd_set(dd_set), .dd_clr(dd_clr), .uf_set(uf_set), .uf_clr(uf_clr),
        .alu_valid(alu_valid), .alu_word(alu_word), .alu_arith(alu_arith),
        .alu_result(alu_result), .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
        .irq_entry(irq_entry), .rti(rti), .rti_psw(rti_psw), .irq_pend(irq_pend),
        .psw(psw), .dd_seen(dd_seen), .push_img(push_img), .mie(mie), .irq_take(irq_take)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state: st 0 = running, 1 = saving, 2 = in service
    logic [15:0] m_psw, m_push;
    logic        m_seen;
    int          m_st;
    int          flag_bit[6] = '{3, 6, 10, 7, 4, 5};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_ld_word = 0; acc_ld_byte = 0; dd_set = 0; dd_clr = 0;
        uf_set = '0; uf_clr = '0; alu_valid = 0; alu_word = 0; alu_arith = 0;
        alu_result = '0; psw_wr_en = 0; psw_wr_data = '0; irq_entry = 0;
        rti = 0; rti_psw = '0; irq_pend = 0; rst = 0;
    endtask

    task automatic step();
        logic [15:0] n;
        logic        ns;
        int          sv;
        #1;
        chk("R11 irq_take", irq_take, irq_pend & m_psw[8] & (m_st != 1));
        n = m_psw;
        if (rti && m_st == 2) n = rti_psw;
        else if (psw_wr_en)   n = psw_wr_data;
        n[15:13] = 3'b000;
        if (acc_ld_word || dd_set)      n[12] = 1'b1;
        else if (acc_ld_byte || dd_clr) n[12] = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (uf_set[i])      n[flag_bit[i]] = 1'b1;
            else if (uf_clr[i]) n[flag_bit[i]] = 1'b0;
        end
        if (alu_valid) begin
            n[11] = alu_word ? alu_result[15] : alu_result[7];
            if (alu_arith) begin
                sv = int'($signed(alu_result));
                if (alu_word) n[9] = (sv < -32768) || (sv > 32767);
                else          n[9] = (sv < -128) || (sv > 127);
            end
        end
        if (m_st == 1) n[8] = 1'b0;
        if (acc_ld_word || dd_set)      ns = 1'b1;
        else if (acc_ld_byte || dd_clr) ns = 1'b0;
        else                            ns = m_psw[12];
        @(posedge clk);
        if (rst) begin
            m_psw = '0; m_push = '0; m_seen = 0; m_st = 0;
        end else begin
            if (m_st == 0 && irq_entry) m_push = m_psw;
            if (m_st == 0)      m_st = irq_entry ? 1 : 0;
            else if (m_st == 1) m_st = 2;
            else if (rti)       m_st = 0;
            m_psw = n;
            m_seen = ns;
        end
        @(negedge clk);
        chk("R8 psw", psw, m_psw);
        chk("R3 dd_seen", dd_seen, m_seen);
        chk("R9 push_img", push_img, m_push);
        chk("R10 mie", mie, m_psw[8]);
        chk("R2 upper bits", psw[15:13], 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        step();
        rst = 0;
        @(negedge clk);
        chk("R1 psw after reset", psw, 16'h0000);
        chk("R1 dd_seen after reset", dd_seen, 0);
        chk("R1 push_img after reset", push_img, 16'h0000);
        chk("R1 mie after reset", mie, 0);

        // full write lags the data-width view
        psw_wr_en = 1; psw_wr_data = 16'hFFFF; step(); idle();
        chk("R2 masked write", psw, 16'h1FFF);
        chk("R4 view lags", dd_seen, 0);
        step();
        chk("R4 view follows", dd_seen, 1);

        acc_ld_byte = 1; step(); idle();
        chk("R3 byte load", {psw[12], dd_seen}, 2'b00);
        dd_set = 1; dd_clr = 1; step(); idle();
        chk("R3 set wins", {psw[12], dd_seen}, 2'b11);

        // ALU flags on range boundaries
        alu_valid = 1; alu_arith = 1; alu_word = 0; alu_result = 17'h00080; step();
        chk("R5 byte sign", psw[11], 1);
        chk("R6 byte 128 overflows", psw[9], 1);
        alu_result = 17'h1FF80; step();
        chk("R6 byte -128 fits", psw[9], 0);
        alu_word = 1; alu_result = 17'h1FFFF; step();
        chk("R5 word sign", psw[11], 1);
        chk("R6 word -1 fits", psw[9], 0);
        alu_result = 17'h08000; step();
        chk("R6 word 32768 overflows", psw[9], 1);
        alu_word = 0; alu_arith = 0; alu_result = 17'h0007F; step(); idle();
        chk("R5 logic sign", psw[11], 0);
        chk("R6 logic keeps ov", psw[9], 1);

        // flag events against a full write
        psw_wr_en = 1; psw_wr_data = 16'h0000; uf_set = 6'b000101; uf_clr = 6'b000001;
        step(); idle();
        chk("R7 R8 flag over write", psw, 16'h0408);

        // interrupt sequence
        psw_wr_en = 1; psw_wr_data = 16'h0100; step(); idle();
        irq_pend = 1; #1;
        chk("R11 take when enabled", irq_take, 1);
        irq_entry = 1; step(); idle();
        chk("R9 image captured", push_img, 16'h0100);
        irq_pend = 1; #1;
        chk("R11 held during save", irq_take, 0);
        step(); idle();
        chk("R9 enable cleared", mie, 0);
        irq_entry = 1; step(); idle();
        chk("R9 entry ignored in service", push_img, 16'h0100);
        rti = 1; rti_psw = 16'hE1A5; step(); idle();
        chk("R10 return reload", psw, 16'h01A5);
        rti = 1; rti_psw = 16'h0000; step(); idle();
        chk("R10 return ignored in run", psw, 16'h01A5);

        // random traffic compared every cycle
        for (int c = 0; c < 4000; c++) begin
            idle();
            rst         = ($urandom_range(0, 299) == 0);
            acc_ld_word = ($urandom_range(0, 9) == 0);
            acc_ld_byte = ($urandom_range(0, 9) == 0);
            dd_set      = ($urandom_range(0, 15) == 0);
            dd_clr      = ($urandom_range(0, 15) == 0);
            uf_set      = 6'($urandom) & 6'($urandom);
            uf_clr      = 6'($urandom) & 6'($urandom);
            alu_valid   = ($urandom_range(0, 2) == 0);
            alu_word    = 1'($urandom);
            alu_arith   = 1'($urandom);
            if ($urandom_range(0, 1) == 0)
                alu_result = 17'($signed(8'($urandom)));
            else
                alu_result = 17'($urandom);
            psw_wr_en   = ($urandom_range(0, 5) == 0);
            psw_wr_data = 16'($urandom);
            irq_entry   = ($urandom_range(0, 7) == 0);
            rti         = ($urandom_range(0, 5) == 0);
            rti_psw     = 16'($urandom);
            irq_pend    = 1'($urandom);
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule